// File: doc/BRIEF.md
# Adaptive Protection Mode Selector

This block chooses, once per atomic sequence, whether a protected memory array runs with errors checked on every read or checked only just before each overwrite. While a sequence runs, it keeps separate tallies of array reads and array writes. When the sequence-end pulse arrives, it weighs the cost of checking every read against the cost of a read-check before every write plus one full scrub. Three per-operation energy weights feed this comparison. The cheaper option becomes the mode for the next sequence.

A privilege flag overrides the decision. Whenever the kernel flag is high, the mode output shows check-on-read, whatever was latched. Deferred checking can leave faulty words in the array, so the block issues a one-cycle scrub request in two cases. The first is when kernel execution begins while check-on-write is in force. The second is when a sequence run under check-on-write comes to an end.

Top module: `prot_mode_sel`

## Requirements
- R1: After reset, `mode_cow` is 0 (check-on-read) and `scrub_req` is 0. Both stay 0 until the first `seq_end` that selects check-on-write.
- R2: Reads (`rd_stb`) and writes (`wr_stb`) are tallied separately, one per cycle in which each strobe is high. A strobe in the same cycle as `seq_end` belongs to the sequence that is starting, not the one that is ending.
- R3: At `seq_end`, check-on-write (`mode_cow`=1 from the following cycle) is selected only if reads×`w_check` > writes×(`w_read`+`w_check`)+`w_scrub`. Any value of the three 16-bit weights is handled without overflow. Equality selects check-on-read.
- R4: The decision uses only the tallies of the sequence just ended. Both tallies restart at zero at every `seq_end`, and `mode_cow` changes only after a `seq_end` or a change of `kernel_mode`.
- R5: Each tally saturates at its all-ones value, 2^CNT_W−1, instead of wrapping.
- R6: While `kernel_mode` is 1, `mode_cow` is 0 in the same cycle. When `kernel_mode` returns to 0, `mode_cow` shows the latched decision again.
- R7: A rise of `kernel_mode` while the latched decision is check-on-write produces `scrub_req`=1 for exactly the next cycle. A rise while the latched decision is check-on-read produces none.
- R8: A `seq_end` in a cycle where `mode_cow` is 1 produces `scrub_req`=1 for exactly the next cycle. A `seq_end` while check-on-read is in effect, including when it is forced by `kernel_mode`, produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb | input | 1 | One array read this cycle |
| wr_stb | input | 1 | One array write this cycle |
| seq_end | input | 1 | Atomic sequence boundary pulse |
| kernel_mode | input | 1 | Privileged execution active |
| w_check | input | WGT_W | Energy weight of one code check |
| w_read | input | WGT_W | Energy weight of one array read |
| w_scrub | input | WGT_W | Energy weight of one full scrub |
| mode_cow | output | 1 | 1 = check-on-write, 0 = check-on-read |
| scrub_req | output | 1 | One-cycle request to scrub the array |

## Verification
A wrong tally stays hidden until the next `seq_end`. It then shows up one cycle later as the wrong value on `mode_cow`. The vectors therefore sit right on the inequality's edge, so that a tally off by one, or a wrapped tally, flips the mode. A wrong latched decision is also exposed through `scrub_req`, one cycle after the next kernel entry or sequence end. A failed override shows up on `mode_cow` in the very cycle that `kernel_mode` rises.

// File: rtl/prot_mode_pkg.sv
package prot_mode_pkg;
  localparam int ACC_W = 64;

  // Check-on-write pays off when per-read checking costs strictly more
  // than a read-check before each write plus one scrub.
  function automatic logic cow_favoured(
    input logic [ACC_W-1:0] n_rd,
    input logic [ACC_W-1:0] n_wr,
    input logic [ACC_W-1:0] e_chk,
    input logic [ACC_W-1:0] e_rd,
    input logic [ACC_W-1:0] e_scr
  );
    logic [ACC_W-1:0] lazy_cost;
    logic [ACC_W-1:0] eager_cost;
    eager_cost = n_rd * e_chk;
    lazy_cost  = n_wr * (e_rd + e_chk) + e_scr;
    return eager_cost > lazy_cost;
  endfunction
endpackage

// File: rtl/access_tally.sv
module access_tally #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         restart,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (restart)
      count <= inc ? ONE : '0;
    else if (inc && count != TOP)
      count <= count + ONE;
  end
endmodule

// File: rtl/energy_judge.sv
module energy_judge
  import prot_mode_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int WGT_W = 16
) (
  input  logic [CNT_W-1:0] n_rd,
  input  logic [CNT_W-1:0] n_wr,
  input  logic [WGT_W-1:0] e_chk,
  input  logic [WGT_W-1:0] e_rd,
  input  logic [WGT_W-1:0] e_scr,
  output logic             pick_cow
);
  always_comb begin
    pick_cow = cow_favoured(ACC_W'(n_rd), ACC_W'(n_wr),
                            ACC_W'(e_chk), ACC_W'(e_rd), ACC_W'(e_scr));
  end
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_end,
  input  logic kernel_mode,
  input  logic pick_cow,
  output logic seq_cow,
  output logic mode_cow,
  output logic scrub_req
);
  logic kernel_q;
  logic kernel_entry;
  logic scrub_now;

  assign mode_cow     = seq_cow & ~kernel_mode;
  assign kernel_entry = kernel_mode & ~kernel_q;
  assign scrub_now    = (kernel_entry & seq_cow) | (seq_end & mode_cow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_cow   <= 1'b0;
      kernel_q  <= 1'b0;
      scrub_req <= 1'b0;
    end else begin
      kernel_q  <= kernel_mode;
      scrub_req <= scrub_now;
      if (seq_end)
        seq_cow <= pick_cow;
    end
  end
endmodule

// File: rtl/prot_mode_sel.sv
module prot_mode_sel #(
  parameter int CNT_W = 32,
  parameter int WGT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic             seq_end,
  input  logic             kernel_mode,
  input  logic [WGT_W-1:0] w_check,
  input  logic [WGT_W-1:0] w_read,
  input  logic [WGT_W-1:0] w_scrub,
  output logic             mode_cow,
  output logic             scrub_req
);
  localparam int N_KIND = 2;

  logic [N_KIND-1:0] stb;
  logic [CNT_W-1:0]  tally [N_KIND];
  logic [CNT_W-1:0]  rd_cnt;
  logic [CNT_W-1:0]  wr_cnt;
  logic              pick_cow;
  logic              seq_cow;

  assign stb    = {wr_stb, rd_stb};
  assign rd_cnt = tally[0];
  assign wr_cnt = tally[1];

  for (genvar k = 0; k < N_KIND; k++) begin : g_tally
    access_tally #(.W(CNT_W)) u_tally (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (stb[k]),
      .restart(seq_end),
      .count  (tally[k])
    );
  end

  energy_judge #(.CNT_W(CNT_W), .WGT_W(WGT_W)) u_judge (
    .n_rd    (rd_cnt),
    .n_wr    (wr_cnt),
    .e_chk   (w_check),
    .e_rd    (w_read),
    .e_scr   (w_scrub),
    .pick_cow(pick_cow)
  );

  mode_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_end    (seq_end),
    .kernel_mode(kernel_mode),
    .pick_cow   (pick_cow),
    .seq_cow    (seq_cow),
    .mode_cow   (mode_cow),
    .scrub_req  (scrub_req)
  );
endmodule

// File: rtl/prot_mode_sel_chk.sv
module prot_mode_sel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seq_end,
  input logic             kernel_mode,
  input logic             mode_cow,
  input logic             scrub_req,
  input logic             seq_cow,
  input logic [CNT_W-1:0] rd_cnt,
  input logic [CNT_W-1:0] wr_cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assert_rd_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(seq_end) |-> (rd_cnt == $past(rd_cnt) || rd_cnt == $past(rd_cnt) + ONE));

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seq_end) |-> (rd_cnt <= ONE && wr_cnt <= ONE));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(seq_end) && !kernel_mode && !$past(kernel_mode)) |-> $stable(mode_cow));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_cnt) == TOP && !$past(seq_end)) |-> wr_cnt == TOP);

  assert_kernel_cor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kernel_mode |-> !mode_cow);

  assert_scrub_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |-> ($past(seq_end) || ($past(kernel_mode) && !$past(kernel_mode, 2))));

  assert_scrub_cow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |-> $past(seq_cow));
endmodule

bind prot_mode_sel prot_mode_sel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .seq_end    (seq_end),
  .kernel_mode(kernel_mode),
  .mode_cow   (mode_cow),
  .scrub_req  (scrub_req),
  .seq_cow    (seq_cow),
  .rd_cnt     (rd_cnt),
  .wr_cnt     (wr_cnt)
);

// File: tb/prot_mode_sel_test.sv
module prot_mode_sel_test;
  localparam int CW = 8;
  localparam int WW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_stb = 1'b0, wr_stb = 1'b0, seq_end = 1'b0, kernel_mode = 1'b0;
  logic [WW-1:0] w_check = '0, w_read = '0, w_scrub = '0;
  logic mode_cow, scrub_req;

  int checks = 0;
  int failures = 0;
  logic prev_cow = 1'b0;

  always #5 clk = ~clk;

  prot_mode_sel #(.CNT_W(CW), .WGT_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .seq_end(seq_end), .kernel_mode(kernel_mode),
    .w_check(w_check), .w_read(w_read), .w_scrub(w_scrub),
    .mode_cow(mode_cow), .scrub_req(scrub_req)
  );

  typedef struct packed {
    logic [15:0] rd;
    logic [15:0] wr;
    logic [15:0] ec;
    logic [15:0] er;
    logic [15:0] es;
    logic        cow;
  } vec_t;

  // reads, writes, w_check, w_read, w_scrub, expected mode
  localparam vec_t VECS [8] = '{
    '{16'd10,  16'd2, 16'd4,     16'd10,    16'd5,     1'b1},
    '{16'd10,  16'd3, 16'd4,     16'd10,    16'd5,     1'b0},
    '{16'd11,  16'd2, 16'd5,     16'd10,    16'd25,    1'b0},
    '{16'd12,  16'd2, 16'd5,     16'd10,    16'd25,    1'b1},
    '{16'd0,   16'd0, 16'd1,     16'd0,     16'd0,     1'b0},
    '{16'd1,   16'd0, 16'd1,     16'd0,     16'd0,     1'b1},
    '{16'd200, 16'd1, 16'd65535, 16'd65535, 16'd65535, 1'b1},
    '{16'd2,   16'd1, 16'd65535, 16'd65535, 16'd65535, 1'b0}
  };

  task automatic chk(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b", what, got, exp);
    end
  endtask

  task automatic accesses(input int n_rd, input int n_wr);
    for (int i = 0; i < n_rd; i++) begin
      rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    end
    for (int i = 0; i < n_wr; i++) begin
      wr_stb = 1'b1; @(negedge clk); wr_stb = 1'b0;
    end
  endtask

  task automatic end_seq();
    seq_end = 1'b1; @(negedge clk); seq_end = 1'b0;
  endtask

  task automatic weights(input logic [15:0] ec, input logic [15:0] er, input logic [15:0] es);
    w_check = ec; w_read = er; w_scrub = es;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode_cow, 1'b0, "R1 mode after reset");
    chk(scrub_req, 1'b0, "R1 scrub after reset");
    weights(16'd1, 16'd0, 16'd0);
    accesses(5, 0);
    chk(mode_cow, 1'b0, "R1 mode before first sequence end");

    // vector table: each entry one sequence
    end_seq();
    prev_cow = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 8; v++) begin
      weights(VECS[v].ec, VECS[v].er, VECS[v].es);
      accesses(int'(VECS[v].rd), int'(VECS[v].wr));
      end_seq();
      chk(mode_cow, VECS[v].cow, $sformatf("R3 vector %0d mode", v));
      chk(scrub_req, prev_cow, $sformatf("R8 vector %0d scrub", v));
      @(negedge clk);
      chk(scrub_req, 1'b0, $sformatf("R8 vector %0d pulse width", v));
      prev_cow = VECS[v].cow;
    end

    // R4: empty sequence after a read-heavy one must judge on zero counts
    weights(16'd1, 16'd0, 16'd0);
    accesses(6, 0);
    end_seq();
    chk(mode_cow, 1'b1, "R4 read-heavy sequence");
    end_seq();
    chk(mode_cow, 1'b0, "R4 empty next sequence uses cleared tallies");
    @(negedge clk);

    // R2: strobe coincident with seq_end counts toward the new sequence
    seq_end = 1'b1; rd_stb = 1'b1; @(negedge clk); seq_end = 1'b0; rd_stb = 1'b0;
    chk(mode_cow, 1'b0, "R2 coincident read not in ending sequence");
    end_seq();
    chk(mode_cow, 1'b1, "R2 coincident read counted in new sequence");
    // R2: writes tallied apart from reads (1*1 > 1*(1+1)+0 false)
    weights(16'd1, 16'd1, 16'd0);
    accesses(1, 1);
    end_seq();
    chk(mode_cow, 1'b0, "R2 writes tallied separately");
    @(negedge clk);

    // R5: 300 reads saturate at 255, 255 > 254
    weights(16'd1, 16'd0, 16'd254);
    accesses(300, 0);
    end_seq();
    chk(mode_cow, 1'b1, "R5 saturated read tally");
    @(negedge clk);

    // R6/R7: kernel entry while check-on-write latched
    kernel_mode = 1'b1; #1;
    chk(mode_cow, 1'b0, "R6 kernel forces check-on-read");
    @(negedge clk);
    chk(scrub_req, 1'b1, "R7 scrub on kernel entry");
    @(negedge clk);
    chk(scrub_req, 1'b0, "R7 scrub single cycle");
    // R8: seq_end inside kernel (forced read-check) -> no scrub
    weights(16'd1, 16'd0, 16'd0);
    accesses(3, 0);
    end_seq();
    chk(scrub_req, 1'b0, "R8 no scrub at sequence end in kernel");
    chk(mode_cow, 1'b0, "R6 still forced after decision");
    kernel_mode = 1'b0; #1;
    chk(mode_cow, 1'b1, "R6 latched decision restored");
    @(negedge clk);
    chk(scrub_req, 1'b0, "R7 no scrub on kernel exit");

    // R7: kernel entry while check-on-read latched -> no scrub
    end_seq();
    chk(mode_cow, 1'b0, "R3 empty sequence picks check-on-read");
    @(negedge clk);
    kernel_mode = 1'b1;
    @(negedge clk);
    chk(scrub_req, 1'b0, "R7 no scrub when read-check latched");
    kernel_mode = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule